// File: doc/BRIEF.md
# Multicycle Processor Core with Sequencing Controller

This block runs a small 32-bit load/store instruction subset one instruction at a time. Each instruction takes several clocks. A single external memory holds both the program and the data. One ALU is reused across the steps of an instruction. The holding registers (instruction, memory data, two operand latches and an ALU result latch) carry values from one step to the next.

A finite-state controller steps through fetch, decode and then an opcode-specific tail. Each step drives a packed bundle of strobes into the datapath. The bundle selects:

- the memory address source (program counter or latched ALU result);
- the two ALU operands;
- the ALU operation class;
- the next program counter source (ALU output, latched ALU result or jump address).

The bundle also sets the unconditional and zero-gated program counter write enables, the register file write enable, its destination field and its write-back source.

The core is used by attaching a memory with combinational read and clocked write to its memory port. Everything the instruction stream does can then be observed on that port.

Top module: `mc_cpu`

## Requirements
- R1: While reset is high, the program counter is 0 and the controller sits in fetch: the port shows a read at address 0 and no write. The first cycle after reset is released is a fetch from address 0.
- R2: In every fetch cycle the port shows a read at the program counter. An instruction that does not transfer control is followed by a fetch at its own address plus 4. Decode cycles make no memory access.
- R3: A load (opcode 100011) takes 5 cycles. Its 4th cycle reads address rs + sign-extended imm[15:0]. The word read is written into register rt.
- R4: A store (opcode 101011) takes 4 cycles. Its 4th cycle writes register rt to address rs + sign-extended imm[15:0]. This is the only cycle with the write strobe high.
- R5: A register-register operation (opcode 000000) takes 4 cycles and writes register rd. The funct field [5:0] selects the operation: 32 add, 34 subtract (rs minus rt), 36 and, 37 or, 39 nor, 42 signed set-less-than (1 when rs < rt, else 0).
- R6: A branch-on-equal (opcode 000100) takes 3 cycles. When rs equals rt, the next fetch is at the branch address + 4 + (sign-extended imm << 2), and negative offsets move backwards. Otherwise the next fetch is at the branch address + 4.
- R7: A jump (opcode 000010) takes 3 cycles. The next fetch is at the upper 4 bits of (jump address + 4), followed by instr[25:0], followed by 00.
- R8: An instruction with any other opcode takes 2 cycles. It writes neither memory nor registers, and the next fetch is at its address + 4.
- R9: Register 0 always reads as zero. A register-register result aimed at it is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| memRdData | input | 32 | Word returned by memory for the current address |
| memAddr | output | 32 | Byte address of the current memory access |
| memWrData | output | 32 | Store data |
| memWrEn | output | 1 | Memory write strobe |
| memRdEn | output | 1 | Memory read strobe (fetch or load) |

## Verification
The hardest cases to reach from the ports are a taken branch with a negative offset and an undefined opcode. Both can only be reached through a program whose earlier instructions have already put known values into registers, because the register file starts at zero. The stimulus therefore loads operands from data words, runs every register-register function and stores each result, and writes to register 0. It then falls through an untaken branch into an undefined opcode. After that it takes a forward branch over two stores, jumps, and branches backwards into a final self-jump. A scoreboard built from an independent instruction-level model predicts the memory-port activity of every cycle. Any step with the wrong cycle count or target is therefore caught in the very cycle it goes astray.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_NOR = 6'd39;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [1:0] {SRCB_REG, SRCB_FOUR, SRCB_IMM, SRCB_IMMX4} srcB_e;
  typedef enum logic [1:0] {ALUOP_ADD, ALUOP_SUB, ALUOP_FUNCT, ALUOP_RSVD} aluOp_e;
  typedef enum logic [1:0] {PCSRC_ALU, PCSRC_OUT, PCSRC_JMP, PCSRC_RSVD} pcSrc_e;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_MEMADR, ST_MEMRD, ST_LDWB,
    ST_MEMWR, ST_EXEC, ST_RWB, ST_BRANCH, ST_JUMP
  } state_e;

  // Strobe bundle from the sequencer to the datapath
  typedef struct packed {
    logic   iOrD;        // memory address: 0 = PC, 1 = latched ALU result
    logic   memRead;
    logic   memWrite;
    logic   irWrite;
    logic   memToReg;    // write-back source: 0 = ALU latch, 1 = memory data latch
    logic   regDst;      // destination field: 0 = rt, 1 = rd
    logic   regWrite;
    logic   aluSrcA;     // 0 = PC, 1 = operand latch A
    srcB_e  aluSrcB;
    aluOp_e aluOp;
    pcSrc_e pcSource;
    logic   pcWrite;
    logic   pcWriteCond;
  } ctrl_t;

endpackage

// File: rtl/mc_control.sv
module mc_control
  import mc_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);

  state_e state, stateNext;
  logic   knownOp;

  assign knownOp = (opcode == OP_RTYPE) || (opcode == OP_LOAD) || (opcode == OP_STORE) ||
                   (opcode == OP_BEQ)   || (opcode == OP_JUMP);

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = ST_FETCH;
    unique case (state)
      ST_FETCH:  stateNext = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OP_LOAD, OP_STORE: stateNext = ST_MEMADR;
          OP_RTYPE:          stateNext = ST_EXEC;
          OP_BEQ:            stateNext = ST_BRANCH;
          OP_JUMP:           stateNext = ST_JUMP;
          default:           stateNext = ST_FETCH;
        endcase
      end
      ST_MEMADR: stateNext = (opcode == OP_STORE) ? ST_MEMWR : ST_MEMRD;
      ST_MEMRD:  stateNext = ST_LDWB;
      ST_EXEC:   stateNext = ST_RWB;
      default:   stateNext = ST_FETCH;
    endcase
  end

  always_comb begin
    ctrl = '0;
    unique case (state)
      ST_FETCH: begin
        ctrl.memRead  = 1'b1;
        ctrl.irWrite  = 1'b1;
        ctrl.aluSrcB  = SRCB_FOUR;
        ctrl.pcWrite  = 1'b1;
      end
      ST_DECODE: ctrl.aluSrcB = SRCB_IMMX4;
      ST_MEMADR: begin
        ctrl.aluSrcA = 1'b1;
        ctrl.aluSrcB = SRCB_IMM;
      end
      ST_MEMRD: begin
        ctrl.memRead = 1'b1;
        ctrl.iOrD    = 1'b1;
      end
      ST_LDWB: begin
        ctrl.regWrite = 1'b1;
        ctrl.memToReg = 1'b1;
      end
      ST_MEMWR: begin
        ctrl.memWrite = 1'b1;
        ctrl.iOrD     = 1'b1;
      end
      ST_EXEC: begin
        ctrl.aluSrcA = 1'b1;
        ctrl.aluOp   = ALUOP_FUNCT;
      end
      ST_RWB: begin
        ctrl.regDst   = 1'b1;
        ctrl.regWrite = 1'b1;
      end
      ST_BRANCH: begin
        ctrl.aluSrcA     = 1'b1;
        ctrl.aluOp       = ALUOP_SUB;
        ctrl.pcWriteCond = 1'b1;
        ctrl.pcSource    = PCSRC_OUT;
      end
      ST_JUMP: begin
        ctrl.pcWrite  = 1'b1;
        ctrl.pcSource = PCSRC_JMP;
      end
      default: ctrl = '0;
    endcase
  end

  // A fetch never repeats in the following cycle
  assert_fetch_single_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl.irWrite |=> !ctrl.irWrite);

  // Load write-back is always preceded by a data read through the ALU latch
  assert_load_order_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LDWB) |-> ($past(ctrl.memRead) && $past(ctrl.iOrD)));

  // A store is the last step of its instruction
  assert_store_last_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl.memWrite |=> ctrl.irWrite);

  // Undefined opcode goes straight back to fetch
  assert_unknown_back_R8: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_DECODE) && !knownOp) |=> (ctrl.irWrite && !ctrl.regWrite));

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_ctrl_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrl_t           ctrlIn,
  output logic [5:0]      opcode,
  input  logic [XLEN-1:0] memRdData,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWrData,
  output logic            memWrEn,
  output logic            memRdEn
);

  localparam int RIDX = $clog2(NREG);
  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

  logic [XLEN-1:0] pc, ir, mdr, regA, regB, aluOut;
  logic [XLEN-1:0] regs [NREG];
  logic [XLEN-1:0] srcA, srcB, aluRes, immExt, pcNext, wData, rdA, rdB;
  logic [RIDX-1:0] rsIdx, rtIdx, rdIdx, wIdx;
  logic [5:0]      funct;
  logic            aluZero, pcEn;

  assign opcode = ir[31:26];
  assign rsIdx  = ir[21 +: RIDX];
  assign rtIdx  = ir[16 +: RIDX];
  assign rdIdx  = ir[11 +: RIDX];
  assign funct  = ir[5:0];
  assign immExt = {{(XLEN-16){ir[15]}}, ir[15:0]};

  // Register file: index 0 reads as zero
  assign rdA = (rsIdx == '0) ? '0 : regs[rsIdx];
  assign rdB = (rtIdx == '0) ? '0 : regs[rtIdx];
  assign wIdx  = ctrlIn.regDst ? rdIdx : rtIdx;
  assign wData = ctrlIn.memToReg ? mdr : aluOut;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (ctrlIn.regWrite && (wIdx != '0)) begin
      regs[wIdx] <= wData;
    end
  end

  // Operand selection and ALU
  assign srcA = ctrlIn.aluSrcA ? regA : pc;

  always_comb begin
    unique case (ctrlIn.aluSrcB)
      SRCB_REG:   srcB = regB;
      SRCB_FOUR:  srcB = WORD_BYTES;
      SRCB_IMM:   srcB = immExt;
      default:    srcB = immExt << 2;
    endcase
  end

  always_comb begin
    aluRes = srcA + srcB;
    if (ctrlIn.aluOp == ALUOP_SUB) begin
      aluRes = srcA - srcB;
    end else if (ctrlIn.aluOp == ALUOP_FUNCT) begin
      case (funct)
        FN_SUB:  aluRes = srcA - srcB;
        FN_AND:  aluRes = srcA & srcB;
        FN_OR:   aluRes = srcA | srcB;
        FN_NOR:  aluRes = ~(srcA | srcB);
        FN_SLT:  aluRes = {{(XLEN-1){1'b0}}, ($signed(srcA) < $signed(srcB))};
        default: aluRes = srcA + srcB;
      endcase
    end
  end
  assign aluZero = (aluRes == '0);

  // Next program counter
  always_comb begin
    unique case (ctrlIn.pcSource)
      PCSRC_ALU: pcNext = aluRes;
      PCSRC_OUT: pcNext = aluOut;
      default:   pcNext = {pc[XLEN-1:XLEN-4], ir[25:0], 2'b00};
    endcase
  end
  assign pcEn = ctrlIn.pcWrite || (ctrlIn.pcWriteCond && aluZero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      ir     <= '0;
      mdr    <= '0;
      regA   <= '0;
      regB   <= '0;
      aluOut <= '0;
    end else begin
      if (pcEn)           pc <= pcNext;
      if (ctrlIn.irWrite) ir <= memRdData;
      mdr    <= memRdData;
      regA   <= rdA;
      regB   <= rdB;
      aluOut <= aluRes;
    end
  end

  // Shared memory port
  assign memAddr   = ctrlIn.iOrD ? aluOut : pc;
  assign memWrData = regB;
  assign memWrEn   = ctrlIn.memWrite;
  assign memRdEn   = ctrlIn.memRead;

  assert_fetch_advance_R2: assert property (@(posedge clk) disable iff (rst)
    ctrlIn.irWrite |=> (pc == $past(pc) + WORD_BYTES));

  assert_branch_taken_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrlIn.pcWriteCond && aluZero) |=> (pc == $past(aluOut)));

  assert_branch_not_taken_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrlIn.pcWriteCond && !aluZero) |=> $stable(pc));

  assert_jump_region_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrlIn.pcWrite && (ctrlIn.pcSource == PCSRC_JMP)) |=>
      ((pc[XLEN-1:XLEN-4] == $past(pc[XLEN-1:XLEN-4])) && (pc[1:0] == 2'b00)));

  assert_zero_reg_R9: assert property (@(posedge clk) disable iff (rst)
    regs[0] == '0);

endmodule

// File: rtl/mc_cpu.sv
module mc_cpu
  import mc_ctrl_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] memRdData,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWrData,
  output logic            memWrEn,
  output logic            memRdEn
);

  ctrl_t      ctrlBus;
  logic [5:0] opcode;

  mc_control control_i (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .ctrl   (ctrlBus)
  );

  mc_datapath #(.XLEN(XLEN), .NREG(NREG)) datapath_i (
    .clk       (clk),
    .rst       (rst),
    .ctrlIn    (ctrlBus),
    .opcode    (opcode),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .memWrEn   (memWrEn),
    .memRdEn   (memRdEn)
  );

endmodule

// File: tb/mc_cpu_tb_top.sv
`timescale 1ns/1ps
module mc_cpu_tb_top;

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] memRdData, memAddr, memWrData;
  logic        memWrEn, memRdEn;

  logic [31:0] mem [256];
  bit          memLoaded = 1'b0;
  bit          doneFlag  = 1'b0;
  int          checkCount = 0;
  int          errCount   = 0;
  exp_t        expQ [$];
  string       tagQ [$];

  always #2.5 clk = ~clk;

  mc_cpu dut_i (
    .clk       (clk),
    .rst       (rst),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .memWrEn   (memWrEn),
    .memRdEn   (memRdEn)
  );

  assign memRdData = mem[memAddr[9:2]];

  function automatic logic [31:0] encR(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] encJ(logic [25:0] tgt);
    return {6'b000010, tgt};
  endfunction

  // Memory model: program and data image, then clocked writes from the port
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[0]  = encI(6'b100011, 0, 1, 16'h0100);
    mem[1]  = encI(6'b100011, 0, 2, 16'h0104);
    mem[2]  = encR(1, 2, 3, 6'd32);
    mem[3]  = encI(6'b101011, 0, 3, 16'h0140);
    mem[4]  = encR(1, 2, 4, 6'd34);
    mem[5]  = encI(6'b101011, 0, 4, 16'h0144);
    mem[6]  = encR(1, 2, 5, 6'd36);
    mem[7]  = encR(1, 2, 6, 6'd37);
    mem[8]  = encR(1, 2, 7, 6'd39);
    mem[9]  = encR(2, 1, 8, 6'd42);
    mem[10] = encR(1, 2, 9, 6'd42);
    mem[11] = encI(6'b101011, 0, 5, 16'h0148);
    mem[12] = encI(6'b101011, 0, 6, 16'h014C);
    mem[13] = encI(6'b101011, 0, 7, 16'h0150);
    mem[14] = encI(6'b101011, 0, 8, 16'h0154);
    mem[15] = encI(6'b101011, 0, 9, 16'h0158);
    mem[16] = encR(1, 1, 0, 6'd32);
    mem[17] = encI(6'b101011, 0, 0, 16'h015C);
    mem[18] = encI(6'b000100, 1, 2, 16'h0005);
    mem[19] = {6'b111111, 26'h0};
    mem[20] = encI(6'b000100, 1, 1, 16'h0002);
    mem[21] = encI(6'b101011, 0, 1, 16'h0168);
    mem[22] = encI(6'b101011, 0, 1, 16'h016C);
    mem[23] = encI(6'b100011, 0, 10, 16'h0108);
    mem[24] = encI(6'b101011, 10, 4, 16'hFFFC);
    mem[25] = encJ(26'd40);
    mem[40] = encI(6'b101011, 0, 3, 16'h0160);
    mem[41] = encJ(26'd44);
    mem[42] = encJ(26'd46);
    mem[44] = encI(6'b000100, 0, 0, 16'hFFFD);
    mem[46] = encJ(26'd46);
    mem[64] = 32'd5;
    mem[65] = 32'hFFFF_FFF9;
    mem[66] = 32'h0000_0180;
    memLoaded = 1'b1;
    forever begin
      @(posedge clk);
      if (!rst && memWrEn) mem[memAddr[9:2]] <= memWrData;
    end
  end

  task automatic push(logic rd, logic wr, logic [31:0] a, logic [31:0] d, string t);
    exp_t e;
    e.rd = rd; e.wr = wr; e.addr = a; e.data = d;
    expQ.push_back(e);
    tagQ.push_back(t);
  endtask

  // Driver: instruction-level model producing the expected port activity per cycle
  task automatic genTrace();
    logic [31:0] sm [256];
    logic [31:0] rf [32];
    string       src [32];
    logic [31:0] pc, w, ea, nxt, a, b, r, imm;
    string       fTag;
    bit          halt;
    for (int i = 0; i < 256; i++) sm[i] = mem[i];
    for (int i = 0; i < 32; i++) begin rf[i] = 32'h0; src[i] = "R3"; end
    pc = 32'h0; fTag = "R1"; halt = 1'b0;
    for (int n = 0; n < 200 && !halt; n++) begin
      w   = sm[pc[9:2]];
      push(1'b1, 1'b0, pc, 32'h0, {fTag, " fetch"});
      push(1'b0, 1'b0, 32'h0, 32'h0, "R2 decode");
      a   = rf[w[25:21]];
      b   = rf[w[20:16]];
      imm = {{16{w[15]}}, w[15:0]};
      pc  = pc + 32'd4;
      fTag = "R2";
      case (w[31:26])
        6'b000000: begin
          push(1'b0, 1'b0, 32'h0, 32'h0, "R5 execute");
          push(1'b0, 1'b0, 32'h0, 32'h0, "R5 writeback");
          case (w[5:0])
            6'd32:   r = a + b;
            6'd34:   r = a - b;
            6'd36:   r = a & b;
            6'd37:   r = a | b;
            6'd39:   r = ~(a | b);
            6'd42:   r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: r = 32'h0;
          endcase
          if (w[15:11] != 5'd0) begin rf[w[15:11]] = r; src[w[15:11]] = "R5"; end
        end
        6'b100011: begin
          ea = a + imm;
          push(1'b0, 1'b0, 32'h0, 32'h0, "R3 address");
          push(1'b1, 1'b0, ea, 32'h0, "R3 read");
          push(1'b0, 1'b0, 32'h0, 32'h0, "R3 writeback");
          if (w[20:16] != 5'd0) begin rf[w[20:16]] = sm[ea[9:2]]; src[w[20:16]] = "R3"; end
        end
        6'b101011: begin
          ea = a + imm;
          push(1'b0, 1'b0, 32'h0, 32'h0, "R4 address");
          push(1'b0, 1'b1, ea, b, {"R4 store of ", (w[20:16] == 5'd0) ? "R9" : src[w[20:16]]});
          sm[ea[9:2]] = b;
        end
        6'b000100: begin
          push(1'b0, 1'b0, 32'h0, 32'h0, "R6 compare");
          if (a == b) pc = pc + (imm << 2);
          fTag = "R6";
        end
        6'b000010: begin
          nxt = {pc[31:28], w[25:0], 2'b00};
          push(1'b0, 1'b0, 32'h0, 32'h0, "R7 jump");
          if (nxt == pc - 32'd4) halt = 1'b1;
          pc = nxt;
          fTag = "R7";
        end
        default: fTag = "R8";
      endcase
    end
  endtask

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      errCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Main sequence and monitor: pop and compare once per cycle, mid-cycle
  initial begin
    exp_t  e;
    string t;
    bit    ok;
    wait (memLoaded);
    genTrace();
    repeat (3) begin
      @(negedge clk); #1;
      check(memRdEn && !memWrEn && (memAddr == 32'h0), "R1 reset state",
            {memRdEn, memWrEn, memAddr[29:0]}, {2'b10, 30'h0});
    end
    rst = 1'b0;
    while (expQ.size() > 0) begin
      e = expQ.pop_front();
      t = tagQ.pop_front();
      ok = (memRdEn == e.rd) && (memWrEn == e.wr) &&
           (!(e.rd || e.wr) || (memAddr == e.addr)) &&
           (!e.wr || (memWrData == e.data));
      checkCount++;
      if (!ok) begin
        errCount++;
        $display("FAIL %s: actual rd=%0b wr=%0b addr=%h data=%h expected rd=%0b wr=%0b addr=%h data=%h",
                 t, memRdEn, memWrEn, memAddr, memWrData, e.rd, e.wr, e.addr, e.data);
      end
      @(negedge clk); #1;
    end
    doneFlag = 1'b1;
  end

  // Watchdog and summary
  initial begin
    int extraErr;
    extraErr = 0;
    fork
      wait (doneFlag);
      begin
        repeat (20000) @(posedge clk);
        if (!doneFlag) begin
          extraErr = 1;
          $display("FAIL watchdog: run did not complete");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checkCount + extraErr, errCount + extraErr);
    $finish;
  end

endmodule